// File: doc/BRIEF.md
# Double-Buffered DAC Code Register

This block sits between a host data bus and the digital input of a 12-bit converter. It holds the converter code in two ranks. The staging rank is three 4-bit registers, and each one is loaded from its own slice of the 12-bit data input. The output rank is a single 12-bit register. It is loaded from the staging rank as a whole, so the code sent to the converter changes only on an explicit transfer and never shows a word that is only partly built.

Every control input is active low. A chip select qualifies four select lines. Lines 0, 1 and 2 each load one staging nibble, and line 3 commands the transfer. Any mix of lines may be low in the same cycle. A host with a narrow bus builds the word over several write cycles and then transfers it. A 12-bit or 16-bit host can write the whole staging rank in one cycle. With every line low, the word goes straight through to the output. Each load completes on a single clock edge, so a strobe one clock long is enough.

Top module: `dac_code_latch`

## Requirements
- R1: A synchronous active-high reset clears both the staging rank and the output rank to zero. A transfer made after reset with no nibble writes gives code 0x000.
- R2: When `cs_n` is low and `sel_n[k]` is low (k = 0, 1, 2), staging nibble k loads `din[4k+3:4k]` on that clock edge. Nibbles that are not selected keep their value.
- R3: While `cs_n` is high, nothing is loaded into either rank, whatever the state of `sel_n` and `din`.
- R4: `code_out` changes only on the edge that follows a cycle with `cs_n` low and `sel_n[3]` low. In every other cycle it holds its value, whatever is on `din`.
- R5: A transfer with `sel_n[2:0]` all high copies the staging rank into the output rank. The bus value present in that cycle has no effect.
- R6: When nibble writes and the transfer are enabled in the same cycle, the output captures the newly written nibbles. With all four lines low, `code_out` equals `din` after one edge.
- R7: A select held low for one clock cycle is enough to complete a load. The result is visible after that single edge.
- R8: Several nibble selects low in one cycle load all of the selected nibbles together. This serves an 8-bit host (two lines) or a 12-bit or 16-bit host (three lines).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| sel_n | input | 4 | Per-register selects, active low; bits 2..0 load nibbles 2..0, bit 3 transfers |
| din | input | 12 | Host data word; nibble k is taken from bits 4k+3..4k |
| code_out | output | 12 | Converter code held in the output rank |

## Verification
On every cycle, the assertions check these properties:
- The output code stays stable unless a qualified transfer was requested.
- A deselected chip freezes both ranks.
- Each selected nibble captures its own bus slice.
- A transfer on its own copies the staging word.
- Full flow-through presents the bus word one edge later.

Only the bench's scenarios can show the host patterns, because they depend on ordered sequences of writes:
- Nibble-by-nibble assembly for a 4-bit host.
- Two-nibble writes for an 8-bit host.
- Single-cycle loads for a 12-bit or 16-bit host.
- A staging rank that is still empty when a transfer follows a reset in the middle of a run.

// File: rtl/dac_code_latch_pkg.sv
package dac_code_latch_pkg;

    // Geometry of the register bank
    localparam int NIB_W    = 4;
    localparam int NIB_CNT  = 3;
    localparam int WORD_W   = NIB_W * NIB_CNT;
    localparam int SEL_W    = NIB_CNT + 1;
    localparam int XFER_IDX = NIB_CNT;

    // Decoded, active-high strobes
    typedef struct packed {
        logic               xfer;
        logic [NIB_CNT-1:0] load;
    } strobe_t;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NIB_W-1:0]  nib_t;

    // Turn active-low chip select and selects into active-high strobes
    function automatic strobe_t decode_strobes(input logic cs_n_i,
                                               input logic [SEL_W-1:0] sel_n_i);
        strobe_t s;
        s.xfer = ~cs_n_i & ~sel_n_i[XFER_IDX];
        for (int k = 0; k < NIB_CNT; k++) begin
            s.load[k] = ~cs_n_i & ~sel_n_i[k];
        end
        return s;
    endfunction

    // Extract nibble k of a word
    function automatic nib_t nibble_of(input word_t w, input int k);
        return w[k*NIB_W +: NIB_W];
    endfunction

endpackage

// File: rtl/dcl_strobe_dec.sv
module dcl_strobe_dec
    import dac_code_latch_pkg::*;
(
    input  logic             cs_n,
    input  logic [SEL_W-1:0] sel_n,
    output strobe_t          strobes
);

    always_comb begin
        strobes = decode_strobes(cs_n, sel_n);
    end

endmodule

// File: rtl/dcl_nibble_reg.sv
module dcl_nibble_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/dcl_out_reg.sv
module dcl_out_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         xfer,
    input  logic [W-1:0] staged_next,
    output logic [W-1:0] code
);

    // Output rank: fed only from the staging rank (including this cycle's writes)
    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else if (xfer) begin
            code <= staged_next;
        end
    end

endmodule

// File: rtl/dac_code_latch.sv
module dac_code_latch
    import dac_code_latch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic [SEL_W-1:0]  sel_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] code_out
);

    strobe_t strobes;
    word_t   rank1_word;
    word_t   rank1_next;

    dcl_strobe_dec u_dec (
        .cs_n    (cs_n),
        .sel_n   (sel_n),
        .strobes (strobes)
    );

    // Staging rank: one register per nibble, each fed from its own bus slice
    for (genvar k = 0; k < NIB_CNT; k++) begin : g_nib
        nib_t slice_in;
        nib_t slice_q;

        assign slice_in = din[k*NIB_W +: NIB_W];

        dcl_nibble_reg #(.W(NIB_W)) u_nib (
            .clk  (clk),
            .rst  (rst),
            .load (strobes.load[k]),
            .d    (slice_in),
            .q    (slice_q)
        );

        assign rank1_word[k*NIB_W +: NIB_W] = slice_q;
        // Flow-through view: a nibble written this cycle reaches the output rank at once
        assign rank1_next[k*NIB_W +: NIB_W] = strobes.load[k] ? slice_in : slice_q;
    end

    dcl_out_reg #(.W(WORD_W)) u_out (
        .clk         (clk),
        .rst         (rst),
        .xfer        (strobes.xfer),
        .staged_next (rank1_next),
        .code        (code_out)
    );

endmodule

// File: rtl/dac_code_latch_chk.sv
module dac_code_latch_chk
    import dac_code_latch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic [SEL_W-1:0]  sel_n,
    input logic [WORD_W-1:0] din,
    input logic [WORD_W-1:0] rank1,
    input logic [WORD_W-1:0] code_out
);

    logic xfer_req;
    assign xfer_req = !cs_n && !sel_n[XFER_IDX];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (code_out == '0 && rank1 == '0)); // R1

    for (genvar k = 0; k < NIB_CNT; k++) begin : g_nib_chk
        AST_NIBBLE_LOAD: assert property (@(posedge clk) disable iff (rst)
            (!cs_n && !sel_n[k]) |=> rank1[k*NIB_W +: NIB_W] == $past(din[k*NIB_W +: NIB_W])); // R2
    end

    AST_CS_FREEZE: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(rank1) && $stable(code_out))); // R3

    AST_HOLD_NO_XFER: assert property (@(posedge clk) disable iff (rst)
        !xfer_req |=> $stable(code_out)); // R4

    AST_XFER_COPY: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && (&sel_n[NIB_CNT-1:0])) |=> code_out == $past(rank1)); // R5

    AST_FULL_FLOW: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && sel_n == '0) |=> code_out == $past(din)); // R6

endmodule

bind dac_code_latch dac_code_latch_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sel_n    (sel_n),
    .din      (din),
    .rank1    (rank1_word),
    .code_out (code_out)
);

// File: tb/dac_code_latch_bench.sv
module dac_code_latch_bench;

    localparam int NVEC = 17;
    localparam int VW   = 1 + 4 + 12 + 12;

    // {cs_n, sel_n[3:0], din, expected code_out after the edge}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {1'b0, 4'b1110, 12'hABC, 12'h000},  // R2 4-bit host nibble 0
        {1'b0, 4'b1101, 12'h5D7, 12'h000},  // R2 nibble 1
        {1'b0, 4'b1011, 12'h9E1, 12'h000},  // R2 nibble 2
        {1'b0, 4'b0111, 12'h123, 12'h9DC},  // R5 transfer copies staging
        {1'b1, 4'b0000, 12'hFFF, 12'h9DC},  // R3 deselected
        {1'b0, 4'b1100, 12'h3A5, 12'h9DC},  // R8 8-bit host low byte
        {1'b0, 4'b1011, 12'h7FF, 12'h9DC},  // R8 8-bit host high part
        {1'b0, 4'b0111, 12'h000, 12'h7A5},  // R5
        {1'b0, 4'b1000, 12'h468, 12'h7A5},  // R8 12-bit host one cycle
        {1'b0, 4'b0111, 12'hFFF, 12'h468},  // R5
        {1'b0, 4'b0000, 12'hB2E, 12'hB2E},  // R6 full flow-through
        {1'b0, 4'b0110, 12'h0C0, 12'hB20},  // R6 partial flow-through
        {1'b0, 4'b1111, 12'h555, 12'hB20},  // R4 no select
        {1'b1, 4'b0111, 12'h000, 12'hB20},  // R3 transfer blocked
        {1'b0, 4'b0111, 12'h999, 12'hB20},  // R3 staging untouched, R5
        {1'b0, 4'b1000, 12'hFFF, 12'hB20},  // R8 16-bit host
        {1'b0, 4'b0111, 12'h000, 12'hFFF}   // R5
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n;
    logic [3:0]  sel_n;
    logic [11:0] din;
    logic [11:0] code_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dac_code_latch u_dac_code_latch (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .sel_n    (sel_n),
        .din      (din),
        .code_out (code_out)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: code_out=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic [3:0] s, input logic [11:0] d);
        cs_n  = c;
        sel_n = s;
        din   = d;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: code_out=%h expected=done", code_out);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] prev_code;
        logic        prev_xfer;

        rst = 1'b1;
        drive(1'b1, 4'hF, 12'h000);
        repeat (3) @(negedge clk);
        check("R1 reset state", code_out, 12'h000);
        rst = 1'b0;

        // Vector walk: drive at the falling edge, check at the next falling edge
        prev_code = code_out;
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][28], VEC[i][27:24], VEC[i][23:12]);
            prev_xfer = !VEC[i][28] && !VEC[i][27];
            @(negedge clk);
            check($sformatf("R7 vector %0d", i), code_out, VEC[i][11:0]);
            if (!prev_xfer) begin
                check($sformatf("R4 hold at vector %0d", i), code_out, prev_code);
            end
            prev_code = code_out;
        end

        // R1: reset mid-run clears both ranks
        rst = 1'b1;
        drive(1'b1, 4'hF, 12'h777);
        @(negedge clk);
        check("R1 mid-run reset", code_out, 12'h000);
        rst = 1'b0;
        drive(1'b0, 4'b0111, 12'hEEE);
        @(negedge clk);
        check("R1 staging cleared", code_out, 12'h000);

        // R7: a one-cycle strobe loads; R2 other nibbles untouched
        drive(1'b0, 4'b1110, 12'h00A);
        @(negedge clk);
        drive(1'b0, 4'b0111, 12'h3C0);
        @(negedge clk);
        check("R7 one-cycle strobe", code_out, 12'h00A);

        // R4: bus toggling with no select leaves the code alone
        drive(1'b0, 4'b1111, 12'hF5F);
        @(negedge clk);
        drive(1'b1, 4'b0000, 12'h0A0);
        @(negedge clk);
        check("R4 bus noise", code_out, 12'h00A);

        // R2: writing nibble 1 only keeps nibbles 0 and 2
        drive(1'b0, 4'b1101, 12'hF6F);
        @(negedge clk);
        drive(1'b0, 4'b0111, 12'h000);
        @(negedge clk);
        check("R2 single nibble", code_out, 12'h06A);

        drive(1'b1, 4'hF, 12'h000);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule